// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the combinational arithmetic and logic core of an eight-bit accumulator machine. It takes the accumulator, a second operand byte, a three-bit operation code, a group select and the current flag byte. It returns a result byte, a write strobe that tells the register file whether to store the result, and the next flag byte. Nothing is registered. Everything settles within the same cycle as the inputs.

With the group select low, the operation code picks one of eight two-operand operations: add, add with carry, subtract, subtract with carry, AND, XOR, OR and compare. With the group select high, the same code picks a single-operand or flag-only operation. Increment and decrement work on the second operand. Negate and complement work on the accumulator. Set-carry and complement-carry change only the flag byte. Flag byte bit positions: sign = 7, zero = 6, half-carry = 4, parity/overflow = 2, subtract = 1, carry = 0. Bits 5 and 3 are not computed.

Top module: `acc_alu`

## Requirements
- R1: With `unary_i`=0, `op_i` selects 0=add, 1=add-with-carry, 2=subtract, 3=subtract-with-carry, 4=AND, 5=XOR, 6=OR, 7=compare. For every one of these, flag bit 7 equals result bit 7 and flag bit 6 is set exactly when the result is zero.
- R2: Add and add-with-carry (the latter also adds flag bit 0) write the sum. Bit 4 is the carry out of bit 3. Bit 2 is signed overflow. Bit 1 is cleared. Bit 0 is the carry out of bit 7.
- R3: Subtract and subtract-with-carry (the latter also subtracts flag bit 0) write the difference. Bit 4 is the borrow out of bit 3. Bit 2 is signed overflow. Bit 1 is set. Bit 0 is the borrow out of bit 7.
- R4: AND, XOR and OR write the bitwise result. Bit 2 is set when the result has an even number of ones. Bits 1 and 0 are cleared. Bit 4 is set for AND and cleared for XOR and OR.
- R5: Compare produces the flags of a subtraction and drives the difference on `result_o`, but `wr_en_o` stays 0.
- R6: With `unary_i`=1, code 0 (increment) and code 1 (decrement) write the second operand plus or minus one. They set bits 7, 6, 4 and 2 as for add and subtract, and set bit 1 to 0 for increment and 1 for decrement. Bit 0 is left unchanged.
- R7: Unary code 2 (negate) writes zero minus the accumulator, with subtract flags. Carry is set exactly when the accumulator is nonzero.
- R8: Unary code 3 (complement) writes the bitwise inverse of the accumulator. It sets bits 4 and 1 and leaves all other flag bits unchanged.
- R9: Unary code 4 (set-carry) sets bit 0 and clears bits 4 and 1. Unary code 5 (complement-carry) inverts bit 0, copies the old bit 0 into bit 4 and clears bit 1. Neither writes, and both present the accumulator on `result_o`.
- R10: Flag bits 5 and 3 always pass from `flags_i` to `flags_o` unchanged.
- R11: Unary codes 6 and 7 have no effect: `wr_en_o`=0, `flags_o` equals `flags_i`, and `result_o` equals the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | DATA_W | Accumulator operand |
| src_i | input | DATA_W | Second operand; the target of increment and decrement |
| op_i | input | 3 | Operation code within the selected group |
| unary_i | input | 1 | 0 = two-operand group, 1 = single-operand and flag group |
| flags_i | input | 8 | Current flag byte |
| result_o | output | DATA_W | Computed result byte |
| wr_en_o | output | 1 | Result is to be written back |
| flags_o | output | 8 | Next flag byte |

## Verification
The bench builds the block with the default data width of eight. At that width the nibble boundary, the sign bit and the wraparound values 0x7F, 0x80, 0xFF and 0x00 can all be reached with directly chosen operands. This lets every half-carry, overflow and borrow corner be driven on purpose. The incoming flag byte is varied so that preserved bits, the carry-in of the carry-using operations and the pass-through bits 5 and 3 are each seen at both values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned FLG_S = 7;
  localparam int unsigned FLG_Z = 6;
  localparam int unsigned FLG_H = 4;
  localparam int unsigned FLG_V = 2;
  localparam int unsigned FLG_N = 1;
  localparam int unsigned FLG_C = 0;

  typedef enum logic [2:0] {
    G_ADD = 3'd0, G_ADC = 3'd1, G_SUB = 3'd2, G_SBC = 3'd3,
    G_AND = 3'd4, G_XOR = 3'd5, G_OR  = 3'd6, G_CMP = 3'd7
  } grp_op_e;

  typedef enum logic [2:0] {
    U_INC = 3'd0, U_DEC = 3'd1, U_NEG = 3'd2, U_CPL = 3'd3,
    U_SCF = 3'd4, U_CCF = 3'd5, U_RS6 = 3'd6, U_RS7 = 3'd7
  } un_op_e;
endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              unary_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic              cin_o,
  output logic              sub_o
);
  always_comb begin
    a_o   = acc_i;
    b_o   = src_i;
    cin_o = 1'b0;
    sub_o = 1'b0;
    if (!unary_i) begin
      case (op_i)
        G_ADC: cin_o = carry_i;
        G_SUB: sub_o = 1'b1;
        G_SBC: begin sub_o = 1'b1; cin_o = carry_i; end
        G_CMP: sub_o = 1'b1;
        default: ;
      endcase
    end else begin
      case (op_i)
        U_INC: begin a_o = src_i; b_o = '0; cin_o = 1'b1; end
        U_DEC: begin a_o = src_i; b_o = '0; cin_o = 1'b1; sub_o = 1'b1; end
        U_NEG: begin a_o = '0; b_o = acc_i; sub_o = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HALF_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [HALF_W:0]   lo;
  logic [DATA_W:0]   full;

  // subtraction as a + ~b + ~borrow_in; carries inverted back to borrows
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = cin_i ^ sub_i;
  assign lo    = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]} + {{HALF_W{1'b0}}, c_eff};
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
  assign sum_o = full[MSB:0];
  assign c_o   = full[DATA_W] ^ sub_i;
  assign h_o   = lo[HALF_W] ^ sub_i;
  assign v_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (op_i)
      G_XOR:   res_o = a_i ^ b_i;
      G_OR:    res_o = a_i | b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [2:0]        op_i,
  input  logic              unary_i,
  input  logic [7:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [7:0]        flags_o
);
  localparam int unsigned MSB    = DATA_W - 1;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] op_a, op_b, as_res, lg_res;
  logic              op_cin, op_sub, as_c, as_h, as_v;
  logic              is_logic;

  acc_alu_opsel #(.DATA_W(DATA_W)) u_opsel (
    .unary_i (unary_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .src_i   (src_i),
    .carry_i (flags_i[FLG_C]),
    .a_o     (op_a),
    .b_o     (op_b),
    .cin_o   (op_cin),
    .sub_o   (op_sub)
  );

  acc_alu_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_addsub (
    .a_i   (op_a),
    .b_i   (op_b),
    .cin_i (op_cin),
    .sub_i (op_sub),
    .sum_o (as_res),
    .c_o   (as_c),
    .h_o   (as_h),
    .v_o   (as_v)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op_i),
    .a_i   (acc_i),
    .b_i   (src_i),
    .res_o (lg_res)
  );

  assign is_logic = (op_i == G_AND) || (op_i == G_XOR) || (op_i == G_OR);

  always_comb begin
    result_o = acc_i;
    wr_en_o  = 1'b0;
    flags_o  = flags_i;
    if (!unary_i) begin
      if (is_logic) begin
        result_o       = lg_res;
        wr_en_o        = 1'b1;
        flags_o[FLG_H] = (op_i == G_AND);
        flags_o[FLG_V] = ~^lg_res;
        flags_o[FLG_N] = 1'b0;
        flags_o[FLG_C] = 1'b0;
      end else begin
        result_o       = as_res;
        wr_en_o        = (op_i != G_CMP);
        flags_o[FLG_H] = as_h;
        flags_o[FLG_V] = as_v;
        flags_o[FLG_N] = op_sub;
        flags_o[FLG_C] = as_c;
      end
      flags_o[FLG_S] = result_o[MSB];
      flags_o[FLG_Z] = (result_o == '0);
    end else begin
      case (op_i)
        U_INC, U_DEC, U_NEG: begin
          result_o       = as_res;
          wr_en_o        = 1'b1;
          flags_o[FLG_S] = as_res[MSB];
          flags_o[FLG_Z] = (as_res == '0);
          flags_o[FLG_H] = as_h;
          flags_o[FLG_V] = as_v;
          flags_o[FLG_N] = op_sub;
          if (op_i == U_NEG) flags_o[FLG_C] = as_c;
        end
        U_CPL: begin
          result_o       = ~acc_i;
          wr_en_o        = 1'b1;
          flags_o[FLG_H] = 1'b1;
          flags_o[FLG_N] = 1'b1;
        end
        U_SCF: begin
          flags_o[FLG_C] = 1'b1;
          flags_o[FLG_H] = 1'b0;
          flags_o[FLG_N] = 1'b0;
        end
        U_CCF: begin
          flags_o[FLG_C] = ~flags_i[FLG_C];
          flags_o[FLG_H] = flags_i[FLG_C];
          flags_o[FLG_N] = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] src_i,
  input logic [2:0]        op_i,
  input logic              unary_i,
  input logic [7:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [7:0]        flags_o
);
  always_comb begin
    if (!$isunknown({acc_i, src_i, op_i, unary_i, flags_i})) begin
      p_pass_bits_r10: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
        else $error("R10 flag bits 5/3 altered");
      if (!unary_i) begin
        p_zero_sign_r1: assert (flags_o[6] == (result_o == '0) && flags_o[7] == result_o[DATA_W-1])
          else $error("R1 sign/zero inconsistent with result");
        if (op_i == 3'd7) begin
          p_cmp_no_write_r5: assert (!wr_en_o && flags_o[1])
            else $error("R5 compare wrote or lacked subtract flag");
        end
        if (op_i >= 3'd4 && op_i <= 3'd6) begin
          p_logic_flags_r4: assert (!flags_o[1] && !flags_o[0] && flags_o[2] == ~^result_o)
            else $error("R4 logic flags wrong");
        end
      end else begin
        if (op_i <= 3'd1) begin
          p_keep_carry_r6: assert (flags_o[0] == flags_i[0] && wr_en_o)
            else $error("R6 increment/decrement touched carry");
        end
        if (op_i == 3'd4) begin
          p_set_carry_r9: assert (flags_o[0] && !flags_o[1] && !flags_o[4] && !wr_en_o)
            else $error("R9 set-carry flags wrong");
        end
        if (op_i >= 3'd6) begin
          p_reserved_idle_r11: assert (!wr_en_o && flags_o == flags_i && result_o == acc_i)
            else $error("R11 reserved code had an effect");
        end
      end
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .acc_i    (acc_i),
  .src_i    (src_i),
  .op_i     (op_i),
  .unary_i  (unary_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .wr_en_o  (wr_en_o),
  .flags_o  (flags_o)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_VEC  = 27;

  logic              clk;
  logic              rst_ni;
  logic [DATA_W-1:0] acc_i, src_i, result_o;
  logic [2:0]        op_i;
  logic              unary_i, wr_en_o;
  logic [7:0]        flags_i, flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  acc_alu #(.DATA_W(DATA_W)) u0 (
    .acc_i    (acc_i),
    .src_i    (src_i),
    .op_i     (op_i),
    .unary_i  (unary_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {unary, op, acc, src, flags_in, exp_result, exp_we, exp_flags}
  localparam logic [44:0] VEC [N_VEC] = '{
    {1'b0, 3'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 1'b1, 8'h10}, // R2 half carry
    {1'b0, 3'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 1'b1, 8'h94}, // R2 overflow
    {1'b0, 3'd0, 8'hFF, 8'h01, 8'h00, 8'h00, 1'b1, 8'h51}, // R2 carry, R1 zero
    {1'b0, 3'd1, 8'h10, 8'h20, 8'h01, 8'h31, 1'b1, 8'h00}, // R2 carry in
    {1'b0, 3'd1, 8'h0F, 8'h00, 8'h01, 8'h10, 1'b1, 8'h10}, // R2 carry in to half
    {1'b0, 3'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 1'b1, 8'h12}, // R3 half borrow
    {1'b0, 3'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 1'b1, 8'h16}, // R3 overflow
    {1'b0, 3'd3, 8'h00, 8'h00, 8'h01, 8'hFF, 1'b1, 8'h93}, // R3 borrow in
    {1'b0, 3'd3, 8'h10, 8'h0F, 8'h01, 8'h00, 1'b1, 8'h52}, // R3 zero result
    {1'b0, 3'd4, 8'hF0, 8'h3C, 8'h29, 8'h30, 1'b1, 8'h3C}, // R4 AND, R10
    {1'b0, 3'd5, 8'hFF, 8'h01, 8'h00, 8'hFE, 1'b1, 8'h80}, // R4 XOR odd parity
    {1'b0, 3'd6, 8'h00, 8'h00, 8'h13, 8'h00, 1'b1, 8'h44}, // R4 OR zero
    {1'b0, 3'd7, 8'h42, 8'h42, 8'h00, 8'h00, 1'b0, 8'h42}, // R5 equal
    {1'b0, 3'd7, 8'h10, 8'h20, 8'h00, 8'hF0, 1'b0, 8'h83}, // R5 less
    {1'b1, 3'd0, 8'h33, 8'h7F, 8'h01, 8'h80, 1'b1, 8'h95}, // R6 inc overflow
    {1'b1, 3'd0, 8'h33, 8'hFF, 8'h00, 8'h00, 1'b1, 8'h50}, // R6 inc wrap
    {1'b1, 3'd1, 8'h33, 8'h80, 8'h01, 8'h7F, 1'b1, 8'h17}, // R6 dec overflow
    {1'b1, 3'd1, 8'h33, 8'h01, 8'h00, 8'h00, 1'b1, 8'h42}, // R6 dec to zero
    {1'b1, 3'd2, 8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h93}, // R7
    {1'b1, 3'd2, 8'h80, 8'h00, 8'h00, 8'h80, 1'b1, 8'h87}, // R7 overflow
    {1'b1, 3'd2, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 8'h42}, // R7 zero no carry
    {1'b1, 3'd3, 8'h5A, 8'h00, 8'hC1, 8'hA5, 1'b1, 8'hD3}, // R8
    {1'b1, 3'd4, 8'h21, 8'h00, 8'hD2, 8'h21, 1'b0, 8'hC1}, // R9 set carry
    {1'b1, 3'd5, 8'h21, 8'h00, 8'h03, 8'h21, 1'b0, 8'h10}, // R9 ccf from 1
    {1'b1, 3'd5, 8'h21, 8'h00, 8'h00, 8'h21, 1'b0, 8'h01}, // R9 ccf from 0
    {1'b1, 3'd6, 8'h66, 8'h11, 8'hFF, 8'h66, 1'b0, 8'hFF}, // R11
    {1'b0, 3'd0, 8'h01, 8'h01, 8'h28, 8'h02, 1'b1, 8'h28}  // R10 pass bits
  };

  function automatic string req_of(input logic u, input logic [2:0] op);
    if (!u) begin
      case (op)
        3'd0, 3'd1: return "R2";
        3'd2, 3'd3: return "R3";
        3'd7:       return "R5";
        default:    return "R4";
      endcase
    end
    case (op)
      3'd0, 3'd1: return "R6";
      3'd2:       return "R7";
      3'd3:       return "R8";
      3'd4, 3'd5: return "R9";
      default:    return "R11";
    endcase
  endfunction

  task automatic drive(input logic u, input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] s, input logic [7:0] f);
    @(posedge clk);
    unary_i = u; op_i = op; acc_i = a; src_i = s; flags_i = f;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] er, input logic ew,
                       input logic [7:0] ef);
    n_chk++;
    if (result_o !== er || wr_en_o !== ew || flags_o !== ef) begin
      n_fail++;
      $display("FAIL %s: got res=%h we=%b flags=%h, expected res=%h we=%b flags=%h",
               req, result_o, wr_en_o, flags_o, er, ew, ef);
    end
  endtask

  initial begin
    rst_ni  = 1'b0;
    unary_i = 1'b0; op_i = 3'd0; acc_i = '0; src_i = '0; flags_i = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle inputs: add of zeros gives zero with Z set (R1)
    check("R1", 8'h00, 1'b1, 8'h40);

    for (int i = 0; i < N_VEC; i++) begin
      drive(VEC[i][44], VEC[i][43:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      check(req_of(VEC[i][44], VEC[i][43:41]), VEC[i][16:9], VEC[i][8], VEC[i][7:0]);
    end

    // directed corners
    drive(1'b1, 3'd7, 8'hAB, 8'hCD, 8'h5A);            // R11 code 7
    check("R11", 8'hAB, 1'b0, 8'h5A);
    drive(1'b0, 3'd2, 8'h00, 8'h01, 8'h28);            // R3 wrap, R10 bits kept
    check("R3", 8'hFF, 1'b1, 8'hBB);
    drive(1'b0, 3'd1, 8'hFF, 8'hFF, 8'h01);            // R2 carry in, full carry
    check("R2", 8'hFF, 1'b1, 8'h91);
    drive(1'b1, 3'd3, 8'h00, 8'h00, 8'h00);            // R8 all ones result
    check("R8", 8'hFF, 1'b1, 8'h12);
    drive(1'b1, 3'd0, 8'h00, 8'h0F, 8'h01);            // R6 inc half carry keeps C
    check("R6", 8'h10, 1'b1, 8'h11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule